// File: doc/BRIEF.md
# DMA Channel Transfer Setting Validator

This block guards the start of one DMA channel. Software programs the channel's transfer settings: the source and destination beat widths, the start addresses, the destination address step, the block byte count, the request mode and the padding mode. Software then asks for the channel to be enabled. On that request the block checks the whole setting in a single cycle. If the setting is legal, the channel enable is raised and a one-cycle start pulse is given to the transfer engine. If the setting is illegal, the enable is held low, no start pulse is issued, and a sticky setting-error flag is raised. All of this happens before any bus cycle is issued.

The block also holds the two master-port selection bits for source and destination. Writes to them are taken only while the channel is disabled. Moving data and decoding register writes are done by neighbouring blocks.

Top module: `dma_cfg_checker`

## Requirements
- R1: Width codes give log2 of the beat size in bytes (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). Code 3 on either the source or the destination side makes the start attempt fail.
- R2: The block byte count must be non-zero, and its value must be a whole multiple of the source beat size (its three low bits are checked against the source width). Otherwise the start attempt fails.
- R3: The three low bits of the source start address must be aligned to the source beat size, or the start attempt fails.
- R4: The destination start address and the destination address step must both be aligned to the destination beat size, or the start attempt fails.
- R5: In peripheral flow-control mode (software request 0, peripheral flow request 1, destination request 0), the attempt fails when the padding mode selects packing (pad_mode 2 or 3) and the destination width code is larger than the source width code. Zero padding (0), sign extension (1), equal widths and every other request mode raise no fault.
- R6: A start attempt is en_set high while chan_en is 0 and en_clr is low. If every check passes, chan_en and go are both 1 in the next cycle, and go falls again one cycle later.
- R7: If any check fails on a start attempt, chan_en and go stay 0 and cfg_err is 1 in the next cycle.
- R8: cfg_err stays set until err_clr is pulsed. A failing start attempt in the same cycle as err_clr leaves it set.
- R9: en_set while chan_en is 1 has no effect: no go pulse and no new check. en_clr clears chan_en in the next cycle. en_clr wins over a simultaneous en_set, so no check is made and no flag changes.
- R10: port_we loads src_port_d and dst_port_d into src_port and dst_port in the next cycle only while chan_en is 0. While chan_en is 1 the write has no effect.
- R11: After a synchronous active-low reset, chan_en, go, cfg_err, src_port and dst_port are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Enable request pulse |
| en_clr | input | 1 | Disable request pulse |
| err_clr | input | 1 | Clears the sticky setting error |
| src_wlog | input | 2 | Source beat width code |
| dst_wlog | input | 2 | Destination beat width code |
| src_addr | input | ADDR_W | Source start address |
| dst_addr | input | ADDR_W | Destination start address |
| dst_step | input | STEP_W | Destination address step |
| blk_bytes | input | CNT_W | Block size in bytes |
| sw_req | input | 1 | Software request mode bit |
| pf_req | input | 1 | Peripheral flow-control bit |
| dst_req | input | 1 | Request comes from destination |
| pad_mode | input | 2 | Padding/packing mode |
| port_we | input | 1 | Port-selection write strobe |
| src_port_d | input | 1 | Source port value to write |
| dst_port_d | input | 1 | Destination port value to write |
| chan_en | output | 1 | Channel enabled |
| go | output | 1 | One-cycle transfer start pulse |
| cfg_err | output | 1 | Sticky setting-error flag |
| src_port | output | 1 | Source master-port selection |
| dst_port | output | 1 | Destination master-port selection |

## Verification
The assertions watch the control protocol on every cycle:
- a start pulse lasts one cycle and always comes with the enable;
- an attempt the rule logic accepts leads to enable plus start, and an attempt it rejects leads to the error flag with no enable;
- the error flag holds until cleared;
- the port bits hold while enabled;
- enable requests while already enabled never start anything.

Whether the rule logic itself judges each setting correctly cannot be seen from those relations. Only the bench's scenarios show that:
- reserved widths, fractional and zero block sizes, misaligned addresses and steps, and packing under peripheral flow control are each rejected;
- the legal neighbours of each of these cases are accepted.

// File: rtl/dma_cfg_pkg.sv
// Shared types and helpers for the DMA transfer setting validator.
// Assumes beat widths are coded as log2 of the byte count, with code 3 reserved.
package dma_cfg_pkg;

    typedef logic [1:0] wlog_t;

    localparam wlog_t WLOG_RSVD = 2'd3;

    // Number of alignment checks made on each start attempt
    localparam int NUM_ALIGN = 4;

    // One bit per rule that can reject a start attempt
    typedef struct packed {
        logic src_w_rsvd;
        logic dst_w_rsvd;
        logic blk_zero;
        logic blk_frac;
        logic src_mis;
        logic dst_mis;
        logic step_mis;
        logic pack_pfc;
    } fault_t;

    // Low-address bits that must be zero for a beat of the given width
    function automatic logic [2:0] lane_mask(wlog_t w);
        case (w)
            2'd0:    lane_mask = 3'b000;
            2'd1:    lane_mask = 3'b001;
            2'd2:    lane_mask = 3'b011;
            default: lane_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_align.sv
// Alignment rule: flags a value whose low bits are not a multiple of the beat size.
// Assumes VAL_W is larger than 3. Only the three low bits can be non-zero in the mask.
module dma_cfg_align
    import dma_cfg_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic [VAL_W-1:0] value,
    input  wlog_t            wlog,
    output logic             misaligned
);

    localparam int PAD_W = VAL_W - 3;

    logic [VAL_W-1:0] mask_full;

    // Widen the lane mask to the value width
    always_comb begin
        mask_full = {{PAD_W{1'b0}}, lane_mask(wlog)};
    end

    // Any masked bit set means the value is not on a beat boundary
    always_comb begin
        misaligned = |(value & mask_full);
    end

endmodule

// File: rtl/dma_cfg_rules.sv
// Combinational rule set: evaluates every setting rule and reports a fault vector
// plus a single pass bit. Assumes all inputs are stable while en_set is sampled.
module dma_cfg_rules
    import dma_cfg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int CNT_W  = 16
) (
    input  wlog_t             src_wlog,
    input  wlog_t             dst_wlog,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [CNT_W-1:0]  blk_bytes,
    input  logic              sw_req,
    input  logic              pf_req,
    input  logic              dst_req,
    input  logic [1:0]        pad_mode,
    output fault_t            faults,
    output logic              cfg_ok
);

    localparam int W_AC  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;
    localparam int MAX_W = (W_AC > STEP_W) ? W_AC : STEP_W;

    // Alignment slot order: 0 source address, 1 block count, 2 destination address, 3 step
    localparam int SL_SRC  = 0;
    localparam int SL_BLK  = 1;
    localparam int SL_DST  = 2;
    localparam int SL_STEP = 3;

    logic [MAX_W-1:0] slot_val [NUM_ALIGN];
    wlog_t            slot_w   [NUM_ALIGN];
    logic [NUM_ALIGN-1:0] slot_mis;

    logic pfc_mode;
    logic packing;
    logic dst_wider;

    // Route each aligned quantity to its slot, zero-extended to a common width
    always_comb begin
        slot_val[SL_SRC]  = MAX_W'(src_addr);
        slot_val[SL_BLK]  = MAX_W'(blk_bytes);
        slot_val[SL_DST]  = MAX_W'(dst_addr);
        slot_val[SL_STEP] = MAX_W'(dst_step);
        slot_w[SL_SRC]    = src_wlog;
        slot_w[SL_BLK]    = src_wlog;
        slot_w[SL_DST]    = dst_wlog;
        slot_w[SL_STEP]   = dst_wlog;
    end

    for (genvar i = 0; i < NUM_ALIGN; i++) begin : g_align
        dma_cfg_align #(
            .VAL_W(MAX_W)
        ) u_align (
            .value     (slot_val[i]),
            .wlog      (slot_w[i]),
            .misaligned(slot_mis[i])
        );
    end

    // Detect packing under peripheral flow control
    always_comb begin
        pfc_mode  = !sw_req && pf_req && !dst_req;
        packing   = pad_mode[1];
        dst_wider = dst_wlog > src_wlog;
    end

    // Collect every rule into the fault vector
    always_comb begin
        faults.src_w_rsvd = (src_wlog == WLOG_RSVD);
        faults.dst_w_rsvd = (dst_wlog == WLOG_RSVD);
        faults.blk_zero   = (blk_bytes == '0);
        faults.blk_frac   = slot_mis[SL_BLK];
        faults.src_mis    = slot_mis[SL_SRC];
        faults.dst_mis    = slot_mis[SL_DST];
        faults.step_mis   = slot_mis[SL_STEP];
        faults.pack_pfc   = pfc_mode && packing && dst_wider;
    end

    // A setting passes only when no rule fires
    always_comb begin
        cfg_ok = ~|faults;
    end

endmodule

// File: rtl/dma_cfg_ctrl.sv
// Enable, start-pulse, sticky-error and port-lock registers.
// A start attempt is en_set while disabled and without en_clr; it takes cfg_ok as the verdict.
module dma_cfg_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic err_clr,
    input  logic cfg_ok,
    input  logic port_we,
    input  logic src_port_d,
    input  logic dst_port_d,
    output logic chan_en,
    output logic go,
    output logic cfg_err,
    output logic src_port,
    output logic dst_port
);

    logic attempt;
    logic accept;
    logic reject;

    // Classify this cycle's enable request
    always_comb begin
        attempt = en_set && !chan_en && !en_clr;
        accept  = attempt && cfg_ok;
        reject  = attempt && !cfg_ok;
    end

    // Channel enable: raised only by an accepted attempt, dropped by en_clr
    always_ff @(posedge clk) begin
        if (!rst_n)      chan_en <= 1'b0;
        else if (en_clr) chan_en <= 1'b0;
        else if (accept) chan_en <= 1'b1;
    end

    // Start pulse: one cycle, after an accepted attempt
    always_ff @(posedge clk) begin
        if (!rst_n) go <= 1'b0;
        else        go <= accept;
    end

    // Sticky error: set by a rejected attempt, which wins over err_clr
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_err <= 1'b0;
        else if (reject)  cfg_err <= 1'b1;
        else if (err_clr) cfg_err <= 1'b0;
    end

    // Port selection: writable only while the channel is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_port <= 1'b0;
            dst_port <= 1'b0;
        end else if (port_we && !chan_en) begin
            src_port <= src_port_d;
            dst_port <= dst_port_d;
        end
    end

endmodule

// File: rtl/dma_cfg_checker.sv
// Top level of the DMA transfer setting validator: rule logic feeding the control registers.
// Assumes settings are held stable by the register block while en_set is high.
module dma_cfg_checker
    import dma_cfg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              err_clr,
    input  logic [1:0]        src_wlog,
    input  logic [1:0]        dst_wlog,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [CNT_W-1:0]  blk_bytes,
    input  logic              sw_req,
    input  logic              pf_req,
    input  logic              dst_req,
    input  logic [1:0]        pad_mode,
    input  logic              port_we,
    input  logic              src_port_d,
    input  logic              dst_port_d,
    output logic              chan_en,
    output logic              go,
    output logic              cfg_err,
    output logic              src_port,
    output logic              dst_port
);

    fault_t faults;
    logic   cfg_ok;
    logic   fault_any;

    dma_cfg_rules #(
        .ADDR_W(ADDR_W),
        .STEP_W(STEP_W),
        .CNT_W (CNT_W)
    ) u_rules (
        .src_wlog (src_wlog),
        .dst_wlog (dst_wlog),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .dst_step (dst_step),
        .blk_bytes(blk_bytes),
        .sw_req   (sw_req),
        .pf_req   (pf_req),
        .dst_req  (dst_req),
        .pad_mode (pad_mode),
        .faults   (faults),
        .cfg_ok   (cfg_ok)
    );

    // Summary of the fault vector, watched by the bound checker
    always_comb begin
        fault_any = |faults;
    end

    dma_cfg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .err_clr   (err_clr),
        .cfg_ok    (cfg_ok),
        .port_we   (port_we),
        .src_port_d(src_port_d),
        .dst_port_d(dst_port_d),
        .chan_en   (chan_en),
        .go        (go),
        .cfg_err   (cfg_err),
        .src_port  (src_port),
        .dst_port  (dst_port)
    );

endmodule

// File: rtl/dma_cfg_checker_sva.sv
// Protocol assertions for dma_cfg_checker, attached through bind.
// Assumes a synchronous active-low reset; every property is disabled while it is low.
module dma_cfg_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_set,
    input logic             en_clr,
    input logic             err_clr,
    input logic [1:0]       src_wlog,
    input logic [1:0]       dst_wlog,
    input logic [CNT_W-1:0] blk_bytes,
    input logic             cfg_ok,
    input logic             fault_any,
    input logic             chan_en,
    input logic             go,
    input logic             cfg_err,
    input logic             src_port,
    input logic             dst_port
);

    logic attempt;
    always_comb attempt = en_set && !chan_en && !en_clr;

    p_verdict_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok != fault_any);

    p_rsvd_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        attempt && (src_wlog == 2'd3 || dst_wlog == 2'd3) |=> cfg_err && !go);

    p_blk_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        attempt && (blk_bytes == '0) |=> cfg_err && !chan_en);

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        attempt && cfg_ok |=> go && chan_en);

    p_go_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    p_go_with_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> chan_en);

    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        attempt && !cfg_ok |=> cfg_err && !chan_en && !go);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !err_clr |=> cfg_err);

    p_no_recheck_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_set && chan_en |=> !go);

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !chan_en && !go);

    p_port_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(src_port) && $stable(dst_port));

endmodule

bind dma_cfg_checker dma_cfg_checker_sva #(
    .CNT_W(CNT_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .err_clr  (err_clr),
    .src_wlog (src_wlog),
    .dst_wlog (dst_wlog),
    .blk_bytes(blk_bytes),
    .cfg_ok   (cfg_ok),
    .fault_any(fault_any),
    .chan_en  (chan_en),
    .go       (go),
    .cfg_err  (cfg_err),
    .src_port (src_port),
    .dst_port (dst_port)
);

// File: tb/dma_cfg_checker_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model is compared on every clock,
// and directed scenarios check each requirement against hand-derived values.
module dma_cfg_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 0, en_clr = 0, err_clr = 0;
    logic [1:0]  src_wlog = 0, dst_wlog = 0;
    logic [31:0] src_addr = 0, dst_addr = 0;
    logic [15:0] dst_step = 0, blk_bytes = 0;
    logic        sw_req = 0, pf_req = 0, dst_req = 0;
    logic [1:0]  pad_mode = 0;
    logic        port_we = 0, src_port_d = 0, dst_port_d = 0;
    logic        chan_en, go, cfg_err, src_port, dst_port;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    dma_cfg_checker dut_i (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .err_clr(err_clr),
        .src_wlog(src_wlog), .dst_wlog(dst_wlog), .src_addr(src_addr), .dst_addr(dst_addr),
        .dst_step(dst_step), .blk_bytes(blk_bytes), .sw_req(sw_req), .pf_req(pf_req),
        .dst_req(dst_req), .pad_mode(pad_mode), .port_we(port_we), .src_port_d(src_port_d),
        .dst_port_d(dst_port_d), .chan_en(chan_en), .go(go), .cfg_err(cfg_err),
        .src_port(src_port), .dst_port(dst_port)
    );

    // Behavioural model state
    bit m_en, m_go, m_err, m_sp, m_dp;

    function automatic bit legal();
        int sb, db;
        if (src_wlog == 3 || dst_wlog == 3) return 0;
        sb = 1 << src_wlog;
        db = 1 << dst_wlog;
        if (blk_bytes == 0) return 0;
        if (int'(blk_bytes) % sb != 0) return 0;
        if (src_addr % sb != 0) return 0;
        if (dst_addr % db != 0) return 0;
        if (int'(dst_step) % db != 0) return 0;
        if (!sw_req && pf_req && !dst_req && pad_mode >= 2 && dst_wlog > src_wlog) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit try_it, ok, old_en;
        old_en = m_en;
        if (!rst_n) begin
            m_en = 0; m_go = 0; m_err = 0; m_sp = 0; m_dp = 0;
        end else begin
            try_it = en_set && !old_en && !en_clr;
            ok = legal();
            m_go = try_it && ok;
            if (en_clr) m_en = 0;
            else if (try_it && ok) m_en = 1;
            if (try_it && !ok) m_err = 1;
            else if (err_clr) m_err = 0;
            if (port_we && !old_en) begin
                m_sp = src_port_d; m_dp = dst_port_d;
            end
        end
    end

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if ({chan_en, go, cfg_err, src_port, dst_port} !== {m_en, m_go, m_err, m_sp, m_dp}) begin
                n_fail++;
                $display("FAIL %s model compare: actual=%b expected=%b", cur_req,
                         {chan_en, go, cfg_err, src_port, dst_port}, {m_en, m_go, m_err, m_sp, m_dp});
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic setup(int sw, int dw, int sa, int da, int st, int bl,
                         bit s, bit p, bit d, int pm);
        src_wlog = 2'(sw); dst_wlog = 2'(dw);
        src_addr = 32'(sa); dst_addr = 32'(da);
        dst_step = 16'(st); blk_bytes = 16'(bl);
        sw_req = s; pf_req = p; dst_req = d; pad_mode = 2'(pm);
    endtask

    // Attempt a start, check the verdict one cycle later, then return to idle
    task automatic try_start(bit exp_ok, string req);
        cur_req = req;
        en_set = 1;
        @(negedge clk);
        chk(req, "chan_en", chan_en, exp_ok);
        chk(req, "go", go, exp_ok);
        chk(req, "cfg_err", cfg_err, !exp_ok);
        en_set = 0;
        en_clr = 1; err_clr = 1;
        @(negedge clk);
        en_clr = 0; err_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "chan_en", chan_en, 0); chk("R11", "go", go, 0);
        chk("R11", "cfg_err", cfg_err, 0); chk("R11", "src_port", src_port, 0);
        chk("R11", "dst_port", dst_port, 0);

        // R6 legal word-to-word start, go lasts one cycle
        setup(2, 2, 'h100, 'h200, 4, 16, 1, 0, 0, 0);
        cur_req = "R6";
        en_set = 1; @(negedge clk); en_set = 0;
        chk("R6", "chan_en", chan_en, 1); chk("R6", "go", go, 1);
        @(negedge clk);
        chk("R6", "go after one cycle", go, 0); chk("R6", "chan_en held", chan_en, 1);

        // R10 port write while enabled is ignored
        cur_req = "R10";
        port_we = 1; src_port_d = 1; dst_port_d = 1; @(negedge clk); port_we = 0;
        chk("R10", "src_port locked", src_port, 0); chk("R10", "dst_port locked", dst_port, 0);

        // R9 en_set while enabled gives no go; en_clr disables
        cur_req = "R9";
        en_set = 1; src_wlog = 3; @(negedge clk); en_set = 0; src_wlog = 2;
        chk("R9", "no go when enabled", go, 0); chk("R9", "no recheck error", cfg_err, 0);
        en_clr = 1; @(negedge clk); en_clr = 0;
        chk("R9", "en_clr disables", chan_en, 0);

        // R10 port write while disabled is taken
        cur_req = "R10";
        port_we = 1; src_port_d = 1; dst_port_d = 0; @(negedge clk); port_we = 0;
        chk("R10", "src_port written", src_port, 1); chk("R10", "dst_port written", dst_port, 0);

        // R9 en_set with en_clr: no check, no start
        cur_req = "R9";
        setup(3, 2, 0, 0, 0, 16, 1, 0, 0, 0);
        en_set = 1; en_clr = 1; @(negedge clk); en_set = 0; en_clr = 0;
        chk("R9", "en_clr wins chan_en", chan_en, 0); chk("R9", "en_clr wins cfg_err", cfg_err, 0);

        // R1 reserved width codes
        setup(3, 2, 0, 0, 0, 16, 1, 0, 0, 0); try_start(0, "R1");
        setup(2, 3, 0, 0, 0, 16, 1, 0, 0, 0); try_start(0, "R1");
        setup(0, 1, 1, 2, 2, 3, 1, 0, 0, 0); try_start(1, "R1");

        // R2 block count
        setup(2, 2, 0, 0, 0, 6, 1, 0, 0, 0); try_start(0, "R2");
        setup(0, 0, 0, 0, 0, 0, 1, 0, 0, 0); try_start(0, "R2");
        setup(1, 1, 0, 0, 0, 6, 1, 0, 0, 0); try_start(1, "R2");

        // R3 source address alignment
        setup(1, 0, 'h101, 0, 0, 8, 1, 0, 0, 0); try_start(0, "R3");
        setup(2, 0, 'h102, 0, 0, 8, 1, 0, 0, 0); try_start(0, "R3");
        setup(0, 0, 'h107, 'h3, 3, 8, 1, 0, 0, 0); try_start(1, "R3");

        // R4 destination address and step alignment
        setup(0, 2, 0, 'h206, 0, 8, 1, 0, 0, 0); try_start(0, "R4");
        setup(0, 1, 0, 'h206, 3, 8, 1, 0, 0, 0); try_start(0, "R4");
        setup(0, 2, 0, 'h208, 12, 8, 1, 0, 0, 0); try_start(1, "R4");

        // R5 packing under peripheral flow control
        setup(0, 2, 0, 0, 0, 8, 0, 1, 0, 2); try_start(0, "R5");
        setup(1, 2, 0, 0, 0, 8, 0, 1, 0, 3); try_start(0, "R5");
        setup(0, 2, 0, 0, 0, 8, 0, 1, 0, 1); try_start(1, "R5");
        setup(2, 2, 0, 0, 0, 8, 0, 1, 0, 2); try_start(1, "R5");
        setup(0, 2, 0, 0, 0, 8, 1, 1, 0, 2); try_start(1, "R5");
        setup(0, 2, 0, 0, 0, 8, 0, 1, 1, 2); try_start(1, "R5");

        // R7 and R8: failure sets sticky flag; failure beats a same-cycle clear
        cur_req = "R8";
        setup(2, 2, 1, 0, 0, 8, 1, 0, 0, 0);
        en_set = 1; @(negedge clk); en_set = 0;
        chk("R7", "fail sets cfg_err", cfg_err, 1); chk("R7", "fail keeps chan_en low", chan_en, 0);
        chk("R7", "fail gives no go", go, 0);
        repeat (3) @(negedge clk);
        chk("R8", "cfg_err held", cfg_err, 1);
        en_set = 1; err_clr = 1; @(negedge clk); en_set = 0; err_clr = 0;
        chk("R8", "fail beats clear", cfg_err, 1);
        err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R8", "err_clr clears", cfg_err, 0);

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule